// File: doc/BRIEF.md
# Shift-Capable Integer Arithmetic and Logic Unit

This block is the execute-stage datapath of a small load/store processor core. It is purely combinational. It takes two operand words, a separate shift-distance field and an operation code, and returns one result word together with a flag that is high when that word is all zeros. Conditional branches that test two registers for equality run the subtract operation and look only at the flag.

There are eight operations, one for each value of the 3-bit select: wrap-around add and subtract, bitwise AND, OR and NOR, a signed less-than test that returns the word 0 or 1, and left and right logical shifts of operand A. Bitwise inversion comes from NOR with a zero operand. The shift distance always comes from the dedicated field and never from operand B.

A parameter chooses between two adder forms: a bit-level ripple chain built in a generate loop, or a single word-wide sum that the synthesis tool is free to map. Both forms produce the signed-overflow term that the less-than test needs. Another generate loop builds the shifter as a log-depth barrel.

Top module: `ialu_core`

## Requirements
- R1: With op_sel = 0 (add), result equals (opnd_a + opnd_b) mod 2^32. No overflow indication exists.
- R2: With op_sel = 1 (subtract), result equals (opnd_a - opnd_b) mod 2^32.
- R3: With op_sel = 2 the result is the bitwise AND of the operands. With op_sel = 3 it is the bitwise OR.
- R4: With op_sel = 4 the result is the complement of (opnd_a OR opnd_b). With opnd_b = 0 this gives the complement of opnd_a.
- R5: With op_sel = 5 the result is 1 when opnd_a < opnd_b as two's-complement signed values (bit 31 is the sign) and 0 otherwise. Bits 31..1 are always 0. The answer stays correct when opnd_a - opnd_b overflows, for example 0x80000000 versus 1 gives 1.
- R6: With op_sel = 6 the result is opnd_a shifted left by shamt (0 to 31), and the vacated low bits are 0. A shamt of 0 returns opnd_a unchanged.
- R7: With op_sel = 7 the result is opnd_a shifted right by shamt (0 to 31), and the vacated high bits are 0. This is unsigned division by 2^shamt.
- R8: zero is 1 exactly when all 32 result bits are 0. Under subtract this means zero = 1 exactly when opnd_a equals opnd_b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 32 | First operand; the value that is shifted |
| opnd_b | input | 32 | Second operand |
| shamt | input | 5 | Shift distance for the two shift operations |
| op_sel | input | 3 | Operation code, 0 to 7 as listed in R1 to R7 |
| result | output | 32 | Operation result |
| zero | output | 1 | High when result is all zeros |

## Verification
The block holds no state, so any internal fault shows at the ports in the same evaluation as the input that exposes it. A broken carry link shows as a wrong sum only for operands that carry through that bit. A wrong overflow term inverts the less-than answer only when the operand signs differ. A faulty shifter stage corrupts only those shift distances that have that stage's bit set. For these reasons the stimulus mixes random words and random shift distances with directed operands at the sign boundary, full carry chains and shift distances 0 and 31.

// File: rtl/ialu_pkg.sv
package ialu_pkg;
   localparam int OP_W = 3;

   typedef enum logic [OP_W-1:0] {
      OP_ADD = 3'd0,
      OP_SUB = 3'd1,
      OP_AND = 3'd2,
      OP_OR  = 3'd3,
      OP_NOR = 3'd4,
      OP_SLT = 3'd5,
      OP_SLL = 3'd6,
      OP_SRL = 3'd7
   } ialu_op_e;

   typedef enum logic {
      SHIFT_TOWARD_MSB = 1'b0,
      SHIFT_TOWARD_LSB = 1'b1
   } shift_dir_e;
endpackage

// File: rtl/ialu_addsub.sv
module ialu_addsub #(
   parameter int DATA_W     = 32,
   parameter bit USE_RIPPLE = 1'b1
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              minus,
   output logic [DATA_W-1:0] sum,
   output logic              ovf
);
   localparam int MSB = DATA_W - 1;

   logic [DATA_W-1:0] b_eff;
   assign b_eff = b ^ {DATA_W{minus}};

   if (USE_RIPPLE) begin : g_ripple
      logic [DATA_W:0] carry;
      assign carry[0] = minus;
      for (genvar i = 0; i < DATA_W; i++) begin : g_bit
         logic half;
         assign half         = a[i] ^ b_eff[i];
         assign sum[i]       = half ^ carry[i];
         assign carry[i + 1] = (a[i] & b_eff[i]) | (carry[i] & half);
      end
      // signed overflow: carry into sign differs from carry out of sign
      assign ovf = carry[DATA_W] ^ carry[MSB];
   end else begin : g_flat
      assign sum = a + b_eff + {{(DATA_W-1){1'b0}}, minus};
      assign ovf = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
   end
endmodule

// File: rtl/ialu_barrel.sv
module ialu_barrel
   import ialu_pkg::*;
#(
   parameter int         DATA_W  = 32,
   parameter int         SHAMT_W = 5,
   parameter shift_dir_e DIR     = SHIFT_TOWARD_MSB
) (
   input  logic [DATA_W-1:0]  din,
   input  logic [SHAMT_W-1:0] amt,
   output logic [DATA_W-1:0]  dout
);
   logic [DATA_W-1:0] stage [SHAMT_W+1];

   assign stage[0] = din;

   for (genvar s = 0; s < SHAMT_W; s++) begin : g_stage
      localparam int DIST = 1 << s;
      logic [DATA_W-1:0] moved;
      if (DIR == SHIFT_TOWARD_MSB) begin : g_left
         assign moved = {stage[s][DATA_W-1-DIST:0], {DIST{1'b0}}};
      end else begin : g_right
         assign moved = {{DIST{1'b0}}, stage[s][DATA_W-1:DIST]};
      end
      assign stage[s + 1] = amt[s] ? moved : stage[s];
   end

   assign dout = stage[SHAMT_W];
endmodule

// File: rtl/ialu_bitwise.sv
module ialu_bitwise #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] and_w,
   output logic [DATA_W-1:0] or_w,
   output logic [DATA_W-1:0] nor_w
);
   assign and_w = a & b;
   assign or_w  = a | b;
   assign nor_w = ~or_w;
endmodule

// File: rtl/ialu_core.sv
module ialu_core
   import ialu_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int SHAMT_W    = 5,
   parameter bit USE_RIPPLE = 1'b1
) (
   input  logic [DATA_W-1:0]  opnd_a,
   input  logic [DATA_W-1:0]  opnd_b,
   input  logic [SHAMT_W-1:0] shamt,
   input  logic [OP_W-1:0]    op_sel,
   output logic [DATA_W-1:0]  result,
   output logic               zero
);
   localparam int MSB = DATA_W - 1;

   // elaboration-time configuration checks
   if (DATA_W < 4) begin : g_bad_width
      $error("ialu_core: DATA_W must be at least 4");
   end
   if ((1 << SHAMT_W) != DATA_W) begin : g_bad_shamt
      $error("ialu_core: 2**SHAMT_W must equal DATA_W");
   end

   ialu_op_e op;
   assign op = ialu_op_e'(op_sel);

   logic              do_minus;
   logic [DATA_W-1:0] sum_w, and_w, or_w, nor_w, sll_w, srl_w;
   logic              ovf;
   logic              less;

   // every operation except add drives the adder in subtract mode
   assign do_minus = (op != OP_ADD);

   ialu_addsub #(.DATA_W(DATA_W), .USE_RIPPLE(USE_RIPPLE)) u_addsub (
      .a     (opnd_a),
      .b     (opnd_b),
      .minus (do_minus),
      .sum   (sum_w),
      .ovf   (ovf)
   );

   ialu_bitwise #(.DATA_W(DATA_W)) u_bitwise (
      .a     (opnd_a),
      .b     (opnd_b),
      .and_w (and_w),
      .or_w  (or_w),
      .nor_w (nor_w)
   );

   ialu_barrel #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W), .DIR(SHIFT_TOWARD_MSB)) u_shl (
      .din  (opnd_a),
      .amt  (shamt),
      .dout (sll_w)
   );

   ialu_barrel #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W), .DIR(SHIFT_TOWARD_LSB)) u_shr (
      .din  (opnd_a),
      .amt  (shamt),
      .dout (srl_w)
   );

   // the sign of the difference, corrected when the subtraction overflowed
   assign less = sum_w[MSB] ^ ovf;

   always_comb begin
      unique case (op)
         OP_ADD, OP_SUB: result = sum_w;
         OP_AND:         result = and_w;
         OP_OR:          result = or_w;
         OP_NOR:         result = nor_w;
         OP_SLT:         result = {{(DATA_W-1){1'b0}}, less};
         OP_SLL:         result = sll_w;
         OP_SRL:         result = srl_w;
         default:        result = '0;
      endcase
   end

   assign zero = ~|result;
endmodule

// File: rtl/ialu_core_chk.sv
module ialu_core_chk
   import ialu_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int SHAMT_W = 5
) (
   input logic [DATA_W-1:0]  opnd_a,
   input logic [DATA_W-1:0]  opnd_b,
   input logic [SHAMT_W-1:0] shamt,
   input logic [OP_W-1:0]    op_sel,
   input logic [DATA_W-1:0]  result,
   input logic               zero
);
   localparam int MSB = DATA_W - 1;

   always_comb begin
      if (op_sel == OP_ADD)
         p_add_inverse_r1: assert (result - opnd_b == opnd_a)
            else $error("R1 add result does not invert");
      if (op_sel == OP_SUB)
         p_sub_inverse_r2: assert (result + opnd_b == opnd_a)
            else $error("R2 sub result does not invert");
      if (op_sel == OP_AND)
         p_and_subset_r3: assert ((result & ~opnd_a) == '0)
            else $error("R3 AND sets a bit absent from A");
      if (op_sel == OP_OR)
         p_or_cover_r3: assert ((opnd_a & ~result) == '0)
            else $error("R3 OR drops a bit of A");
      if (op_sel == OP_NOR)
         p_nor_disjoint_r4: assert ((result & (opnd_a | opnd_b)) == '0)
            else $error("R4 NOR overlaps an operand bit");
      if (op_sel == OP_SLT)
         p_slt_word_r5: assert (result[MSB:1] == '0)
            else $error("R5 less-than word not 0/1");
      if (op_sel == OP_SLT && opnd_a[MSB] != opnd_b[MSB])
         p_slt_sign_r5: assert (result[0] == opnd_a[MSB])
            else $error("R5 less-than wrong across signs");
      if (op_sel == OP_SLL)
         p_sll_lowfill_r6: assert ((result << (DATA_W - int'(shamt))) == '0)
            else $error("R6 left shift low bits not zero");
      if ((op_sel == OP_SLL || op_sel == OP_SRL) && shamt == '0)
         p_shift_none_r6: assert (result == opnd_a)
            else $error("R6 zero-distance shift changed A");
      if (op_sel == OP_SRL)
         p_srl_highfill_r7: assert ((result >> (DATA_W - int'(shamt))) == '0)
            else $error("R7 right shift high bits not zero");
      if (op_sel == OP_SUB)
         p_sub_equal_r8: assert (zero == (opnd_a == opnd_b))
            else $error("R8 zero flag disagrees with equality");
   end
endmodule

bind ialu_core ialu_core_chk #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_chk (
   .opnd_a (opnd_a),
   .opnd_b (opnd_b),
   .shamt  (shamt),
   .op_sel (op_sel),
   .result (result),
   .zero   (zero)
);

// File: tb/ialu_core_bench.sv
`timescale 1ns/1ps
module ialu_core_bench;
   logic        clk = 1'b0;
   logic [31:0] opnd_a, opnd_b;
   logic [4:0]  shamt;
   logic [2:0]  op_sel;
   logic [31:0] result;
   logic        zero;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;   // 200 MHz

   ialu_core u_ialu_core (
      .opnd_a (opnd_a),
      .opnd_b (opnd_b),
      .shamt  (shamt),
      .op_sel (op_sel),
      .result (result),
      .zero   (zero)
   );

   function automatic logic [31:0] model(input logic [2:0] op, input logic [31:0] a,
                                         input logic [31:0] b, input logic [4:0] sh);
      case (op)
         3'd0: return a + b;
         3'd1: return a - b;
         3'd2: return a & b;
         3'd3: return a | b;
         3'd4: return ~(a | b);
         3'd5: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
         3'd6: return a << sh;
         default: return a >> sh;
      endcase
   endfunction

   function automatic string tag_of(input logic [2:0] op);
      case (op)
         3'd0: return "R1";
         3'd1: return "R2";
         3'd2, 3'd3: return "R3";
         3'd4: return "R4";
         3'd5: return "R5";
         3'd6: return "R6";
         default: return "R7";
      endcase
   endfunction

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   // drive on a rising edge, sample at the following falling edge
   task automatic apply(input string req, input logic [2:0] op, input logic [31:0] a,
                        input logic [31:0] b, input logic [4:0] sh);
      logic [31:0] exp;
      @(posedge clk);
      op_sel = op; opnd_a = a; opnd_b = b; shamt = sh;
      @(negedge clk);
      exp = model(op, a, b, sh);
      check(req, result, exp);
      check({req, " R8 zero flag"}, {31'd0, zero}, {31'd0, exp == 32'd0});
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      int unsigned seed_dummy;
      opnd_a = '0; opnd_b = '0; shamt = '0; op_sel = '0;
      seed_dummy = $urandom(32'd20240611);
      // quiet inputs: sum of zeros, flag set
      apply("R1 idle", 3'd0, 32'h0, 32'h0, 5'd0);
      // directed corners
      apply("R1 wrap", 3'd0, 32'hFFFF_FFFF, 32'h1, 5'd0);
      apply("R1 sign wrap", 3'd0, 32'h7FFF_FFFF, 32'h1, 5'd0);
      apply("R2 borrow", 3'd1, 32'h0, 32'h1, 5'd0);
      apply("R8 equal sub", 3'd1, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 5'd0);
      apply("R8 unequal sub", 3'd1, 32'hDEAD_BEEF, 32'hDEAD_BEEE, 5'd0);
      apply("R3 and mask", 3'd2, 32'hF0F0_1234, 32'h0FF0_FFFF, 5'd0);
      apply("R3 or merge", 3'd3, 32'hF000_0000, 32'h0000_000F, 5'd0);
      apply("R4 not via zero", 3'd4, 32'h1234_5678, 32'h0, 5'd0);
      apply("R4 all ones", 3'd4, 32'hFFFF_0000, 32'h0000_FFFF, 5'd0);
      apply("R5 overflow min<1", 3'd5, 32'h8000_0000, 32'h1, 5'd0);
      apply("R5 max vs -1", 3'd5, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 5'd0);
      apply("R5 -1 vs 0", 3'd5, 32'hFFFF_FFFF, 32'h0, 5'd0);
      apply("R5 equal", 3'd5, 32'h0000_0042, 32'h0000_0042, 5'd0);
      apply("R6 by 0", 3'd6, 32'hA5A5_A5A5, 32'h0, 5'd0);
      apply("R6 by 31", 3'd6, 32'hFFFF_FFFF, 32'h0, 5'd31);
      apply("R6 out", 3'd6, 32'h8000_0000, 32'h0, 5'd1);
      apply("R7 by 31", 3'd7, 32'hFFFF_FFFF, 32'h0, 5'd31);
      apply("R7 divide", 3'd7, 32'h0000_1000, 32'h0, 5'd4);
      apply("R7 by 0", 3'd7, 32'h8000_0001, 32'h0, 5'd0);
      // random mix, with occasional sign-boundary operands
      for (int i = 0; i < 1200; i++) begin
         logic [2:0]  op;
         logic [31:0] a, b;
         op = 3'($urandom_range(7));
         a  = $urandom();
         b  = ($urandom_range(3) == 0) ? a ^ 32'h8000_0000 : $urandom();
         if ($urandom_range(7) == 0) b = a;
         apply(tag_of(op), op, a, b, 5'($urandom_range(31)));
      end
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule